// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and decides, for every incoming frame, whether the frame is kept or discarded. The decision depends only on the 48-bit destination address. The address arrives as six bytes, one byte on each cycle that carries a valid strobe. A start strobe marks the first byte. After the sixth byte the block raises a one-cycle done strobe together with an accept flag.

Configuration comes in on plain input ports and is sampled when the sixth byte arrives. There are five mode bits: receive-all, promiscuous, pass-all-multicast, hash-multicast enable and broadcast-disable. Two more inputs are the 64-bit multicast hash table, split into a high word and a low word, and a table of unicast perfect-match entries, each with its own enable bit.

The multicast hash is the Ethernet CRC-32, updated one byte per cycle as the address bytes arrive.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `done_o` and `accept_o` are 0.
- R2: `done_o` is high for exactly one cycle. That cycle is the one after the sixth valid byte counted from a start. Cycles with `byte_vld_i` low are skipped and do not advance the address. `accept_o` holds the decision while `done_o` is high.
- R3: With `cfg_promisc_i` set, every address is accepted.
- R4: With `cfg_rx_all_i` set, every address is accepted, whatever the other mode bits are.
- R5: The all-ones broadcast address is accepted when `cfg_bcast_dis_i` is 0. It is dropped when that bit is 1, unless R3 or R4 applies. The pass-all-multicast bit does not rescue it.
- R6: A multicast address that is not broadcast is accepted when `cfg_all_mcast_i` is set. An address is multicast when bit 0 of its first byte is 1.
- R7: With `cfg_hash_en_i` set, a non-broadcast multicast address is accepted when its hash bit is 1.
  - The hash is computed as a reflected CRC-32 over the six bytes in arrival order, each byte least significant bit first. The polynomial is 0xEDB88320, the start value is all ones, and the result is complemented. The 32-bit result is then bit-reversed, and bits 31:26 of the reversed value form a 6-bit index.
  - Index bit 5 selects `hash_hi_i` (1) or `hash_lo_i` (0). Index bits 4:0 select the bit within that word.
  - A multicast address is dropped when neither this rule nor R6 accepts it.
- R8: A unicast address (first byte bit 0 is 0) is accepted only when it equals an enabled entry of `uc_tbl_i`.
  - Entry k occupies bits [48k+47:48k], and byte j of the address sits in bits [48k+8j+7:48k+8j].
  - `uc_en_i[k]` enables entry k. A disabled entry never matches.
- R9: A start strobe restarts the byte count and the CRC and discards any incomplete address. A start together with a valid byte makes that byte the first byte. A start in the cycle where a sixth byte would have arrived produces no done.
- R10: Valid bytes that arrive after a completed address, or after reset, with no start are ignored. They produce no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start of a new destination address |
| byte_vld_i | input | 1 | `byte_i` carries an address byte |
| byte_i | input | 8 | Address byte, first byte first |
| cfg_rx_all_i | input | 1 | Accept everything (debug override) |
| cfg_promisc_i | input | 1 | Promiscuous mode |
| cfg_all_mcast_i | input | 1 | Pass all multicast |
| cfg_hash_en_i | input | 1 | Hash-filter multicast |
| cfg_bcast_dis_i | input | 1 | Drop broadcast |
| hash_hi_i | input | 32 | Hash table, index bit 5 = 1 |
| hash_lo_i | input | 32 | Hash table, index bit 5 = 0 |
| uc_tbl_i | input | 48*NUM_UC | Unicast perfect-match entries |
| uc_en_i | input | NUM_UC | Per-entry enable |
| done_o | output | 1 | Decision strobe |
| accept_o | output | 1 | 1 = keep frame, 0 = drop |

## Verification
Two events can meet in one cycle: the done strobe of one address and the start of the next. The bench drives a second address directly behind a first one. It samples the first address's decision in the very cycle the new start and first byte are applied, and then checks the second decision on its own.

A start can also fall into the slot where a sixth byte was due. The bench provokes this by breaking off a broadcast address after five bytes and starting a unicast address in its place. It then requires that no done appears for the broken address and that the final decision belongs to the new address.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
  localparam int CRC_W      = 32;
  localparam int HASH_W     = 6;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;

  // one byte of reflected CRC, lsb first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-BYTE_W){1'b0}}, d};
    for (int i = 0; i < BYTE_W; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rx_filt_crc.sv
module rx_filt_crc
  import rx_filt_pkg::*;
(
  input  logic [CRC_W-1:0]  seed,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  nxt
);
  assign nxt = crc_byte(seed, data);
endmodule

// File: rtl/rx_filt_hash.sv
module rx_filt_hash
  import rx_filt_pkg::*;
#(
  parameter int IDX_W = HASH_W
) (
  input  logic [IDX_W-1:0]        crc_low,
  input  logic [2**(IDX_W-1)-1:0] tbl_hi,
  input  logic [2**(IDX_W-1)-1:0] tbl_lo,
  output logic                    hit
);
  logic [IDX_W-1:0]        idx;
  logic [2**(IDX_W-1)-1:0] word;

  // complement + bit reversal: reversed top bits are the inverted low bits
  for (genvar g = 0; g < IDX_W; g++) begin : g_rev
    assign idx[IDX_W-1-g] = ~crc_low[g];
  end

  assign word = idx[IDX_W-1] ? tbl_hi : tbl_lo;
  assign hit  = word[idx[IDX_W-2:0]];
endmodule

// File: rtl/rx_filt_ucmatch.sv
module rx_filt_ucmatch
  import rx_filt_pkg::*;
#(
  parameter int NUM_UC = 16
) (
  input  logic [NUM_UC*ADDR_W-1:0] tbl,
  input  logic [NUM_UC-1:0]        en,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     hit
);
  logic [NUM_UC-1:0] hits;

  for (genvar k = 0; k < NUM_UC; k++) begin : g_ent
    assign hits[k] = en[k] && (tbl[k*ADDR_W +: ADDR_W] == addr);
  end

  assign hit = |hits;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int NUM_UC = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sof_i,
  input  logic                     byte_vld_i,
  input  logic [BYTE_W-1:0]        byte_i,
  input  logic                     cfg_rx_all_i,
  input  logic                     cfg_promisc_i,
  input  logic                     cfg_all_mcast_i,
  input  logic                     cfg_hash_en_i,
  input  logic                     cfg_bcast_dis_i,
  input  logic [31:0]              hash_hi_i,
  input  logic [31:0]              hash_lo_i,
  input  logic [NUM_UC*ADDR_W-1:0] uc_tbl_i,
  input  logic [NUM_UC-1:0]        uc_en_i,
  output logic                     done_o,
  output logic                     accept_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
  localparam int               HOLD_W   = ADDR_W - BYTE_W;

  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CRC_W-1:0]  crc_q;
  logic [HOLD_W-1:0] addr_q;

  logic [CRC_W-1:0]  crc_seed, crc_nxt;
  logic [ADDR_W-1:0] full_addr;
  logic              last_byte, take, hash_hit, uc_hit, is_mc, is_bc, decide;

  assign crc_seed  = sof_i ? {CRC_W{1'b1}} : crc_q;
  assign take      = byte_vld_i && (sof_i || armed_q);
  assign last_byte = byte_vld_i && !sof_i && armed_q && (cnt_q == LAST_IDX);
  assign full_addr = {byte_i, addr_q};
  assign is_mc     = addr_q[0];
  assign is_bc     = &full_addr;

  rx_filt_crc i_crc (
    .seed (crc_seed),
    .data (byte_i),
    .nxt  (crc_nxt)
  );

  rx_filt_hash #(.IDX_W(HASH_W)) i_hash (
    .crc_low (crc_nxt[HASH_W-1:0]),
    .tbl_hi  (hash_hi_i),
    .tbl_lo  (hash_lo_i),
    .hit     (hash_hit)
  );

  rx_filt_ucmatch #(.NUM_UC(NUM_UC)) i_uc (
    .tbl  (uc_tbl_i),
    .en   (uc_en_i),
    .addr (full_addr),
    .hit  (uc_hit)
  );

  always_comb begin
    if (cfg_rx_all_i || cfg_promisc_i) decide = 1'b1;
    else if (is_bc)                    decide = !cfg_bcast_dis_i;
    else if (is_mc)                    decide = cfg_all_mcast_i || (cfg_hash_en_i && hash_hit);
    else                               decide = uc_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      crc_q    <= '1;
      addr_q   <= '0;
      done_o   <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      done_o <= last_byte;
      if (last_byte) accept_o <= decide;
      if (sof_i) begin
        armed_q <= 1'b1;
        cnt_q   <= byte_vld_i ? CNT_W'(1) : '0;
        crc_q   <= byte_vld_i ? crc_nxt : {CRC_W{1'b1}};
        if (byte_vld_i) addr_q[BYTE_W-1:0] <= byte_i;
      end else if (take) begin
        if (last_byte) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          crc_q <= crc_nxt;
          for (int j = 0; j < ADDR_BYTES - 1; j++)
            if (cnt_q == CNT_W'(j)) addr_q[j*BYTE_W +: BYTE_W] <= byte_i;
        end
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic clk,
  input logic rst,
  input logic sof_i,
  input logic byte_vld_i,
  input logic cfg_promisc_i,
  input logic cfg_rx_all_i,
  input logic done_o,
  input logic accept_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!done_o && !accept_o));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);

  // R2
  done_after_byte_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> $past(byte_vld_i));

  // R3
  promisc_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(cfg_promisc_i)) |-> accept_o);

  // R4
  rx_all_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(cfg_rx_all_i)) |-> accept_o);

  // R9
  restart_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sof_i) |-> !done_o);
endmodule

bind rx_addr_filter rx_addr_filter_chk i_chk (.*);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_UC     = 16;
  localparam int NVEC       = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof = 1'b0, vld = 1'b0;
  logic [7:0] byt = 8'h00;
  logic m_rx_all = 0, m_promisc = 0, m_all_mc = 0, m_hash = 0, m_bdis = 0;
  logic [31:0] hash_hi = 32'hA5A5_0F0F, hash_lo = 32'h3C3C_F00F;
  logic [NUM_UC*48-1:0] uc_tbl;
  logic [NUM_UC-1:0] uc_en = 16'hFFF7;   // entry 3 disabled
  logic done_o, accept_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter #(.NUM_UC(NUM_UC)) i_rx_addr_filter (
    .clk(clk), .rst(rst), .sof_i(sof), .byte_vld_i(vld), .byte_i(byt),
    .cfg_rx_all_i(m_rx_all), .cfg_promisc_i(m_promisc), .cfg_all_mcast_i(m_all_mc),
    .cfg_hash_en_i(m_hash), .cfg_bcast_dis_i(m_bdis),
    .hash_hi_i(hash_hi), .hash_lo_i(hash_lo), .uc_tbl_i(uc_tbl), .uc_en_i(uc_en),
    .done_o(done_o), .accept_o(accept_o));

  // mode {rx_all, promisc, all_mcast, hash_en, bcast_dis}; exp 0 drop, 1 accept, 2 model
  localparam logic [54:0] VEC [NVEC] = '{
    {5'b00000, 2'd1, 48'h4433_2211_0502},
    {5'b00000, 2'd0, 48'h4433_2211_0302},
    {5'b00000, 2'd1, 48'h4433_2211_0F02},
    {5'b00000, 2'd0, 48'h4433_2211_1002},
    {5'b01000, 2'd1, 48'h4433_2211_1002},
    {5'b10000, 2'd1, 48'h4433_2211_1002},
    {5'b00000, 2'd1, 48'hFFFF_FFFF_FFFF},
    {5'b00001, 2'd0, 48'hFFFF_FFFF_FFFF},
    {5'b00101, 2'd0, 48'hFFFF_FFFF_FFFF},
    {5'b01001, 2'd1, 48'hFFFF_FFFF_FFFF},
    {5'b00000, 2'd0, 48'hFB00_005E_0001},
    {5'b00100, 2'd1, 48'hFB00_005E_0001},
    {5'b00010, 2'd2, 48'hFB00_005E_0001},
    {5'b00010, 2'd2, 48'h0100_0000_3333},
    {5'b10001, 2'd1, 48'hFB00_005E_0001}
  };

  function automatic logic [5:0] model_idx(input logic [47:0] a);
    logic [31:0] c, rv;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int j = 0; j < 6; j++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ a[8*j+b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    c = ~c;
    for (int i = 0; i < 32; i++) rv[i] = c[31-i];
    return rv[31:26];
  endfunction

  function automatic logic model_dec(input logic [47:0] a);
    logic [5:0] ix;
    logic m;
    if (m_rx_all || m_promisc) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !m_bdis;
    if (a[0]) begin
      ix = model_idx(a);
      return m_all_mc || (m_hash && (ix[5] ? hash_hi[ix[4:0]] : hash_lo[ix[4:0]]));
    end
    m = 1'b0;
    for (int k = 0; k < NUM_UC; k++)
      if (uc_en[k] && uc_tbl[48*k +: 48] == a) m = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    {m_rx_all, m_promisc, m_all_mc, m_hash, m_bdis} = m;
  endtask

  // drives six bytes; fd/fa = outputs at the first slot, any_d = done seen later
  task automatic drive_bytes(input logic [47:0] a, input int gap_at,
                             output logic fd, output logic fa, output logic any_d);
    any_d = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (j == 0) begin fd = done_o; fa = accept_o; end
      else any_d |= done_o;
      if (gap_at == j) begin
        sof = 0; vld = 0;
        @(negedge clk);
        any_d |= done_o;
      end
      sof = (j == 0); vld = 1; byt = a[8*j +: 8];
    end
  endtask

  task automatic drive_partial(input logic [47:0] a, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      sof = (j == 0); vld = 1; byt = a[8*j +: 8];
    end
  endtask

  task automatic send_chk(input logic [47:0] a, input logic exp, input string req, input int gap_at);
    logic fd, fa, ad;
    drive_bytes(a, gap_at, fd, fa, ad);
    chk({req, " no early done"}, ad, 1'b0);
    @(negedge clk); sof = 0; vld = 0;
    chk({req, " done"}, done_o, 1'b1);
    chk(req, accept_o, exp);
    @(negedge clk);
    chk("R2 single pulse", done_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic fd, fa, ad;
    logic [47:0] a;
    logic [5:0] ix;
    string tag;
    for (int k = 0; k < NUM_UC; k++)
      uc_tbl[48*k +: 48] = {8'h44, 8'h33, 8'h22, 8'h11, 8'(k), 8'h02};

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done_o, 1'b0);
    chk("R1 accept in reset", accept_o, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R1 done after reset", done_o, 1'b0);

    // R10 bytes without start after reset
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      if (j > 0) chk("R10 no start after reset", done_o, 1'b0);
      vld = 1; sof = 0; byt = 8'hFF;
    end
    @(negedge clk); vld = 0;
    chk("R10 no start after reset", done_o, 1'b0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      a = VEC[v][47:0];
      set_mode(VEC[v][54:50]);
      if (m_rx_all) tag = "R4";
      else if (m_promisc) tag = "R3";
      else if (a == 48'hFFFF_FFFF_FFFF) tag = "R5";
      else if (a[0]) tag = m_all_mc ? "R6" : "R7";
      else tag = "R8";
      send_chk(a, (VEC[v][49:48] == 2'd2) ? model_dec(a) : VEC[v][48], tag, -1);
    end

    // R7 hash bit selection, both words
    set_mode(5'b00010);
    for (int t = 0; t < 2; t++) begin
      a = (t == 0) ? 48'hFB00_005E_0001 : 48'h0100_0000_3333;
      ix = model_idx(a);
      hash_hi = 32'h0; hash_lo = 32'h0;
      if (ix[5]) hash_hi[ix[4:0]] = 1'b1; else hash_lo[ix[4:0]] = 1'b1;
      send_chk(a, 1'b1, "R7 hash bit set", -1);
      hash_hi = ~hash_hi; hash_lo = ~hash_lo;
      send_chk(a, 1'b0, "R7 hash bit clear", -1);
    end

    // R2 gaps inside the address
    set_mode(5'b00000);
    send_chk(48'h4433_2211_0502, 1'b1, "R2 gap", 3);

    // R9 restart mid address
    drive_partial(48'hFFFF_FFFF_FFFF, 3);
    send_chk(48'h4433_2211_1002, 1'b0, "R9 restart mid", -1);

    // R9 start in the sixth byte slot
    drive_partial(48'hFFFF_FFFF_FFFF, 5);
    send_chk(48'h4433_2211_1002, 1'b0, "R9 start at sixth", -1);

    // R2 back-to-back: done of first with start of second
    drive_bytes(48'h4433_2211_0502, -1, fd, fa, ad);
    drive_bytes(48'h4433_2211_0302, -1, fd, fa, ad);
    chk("R2 b2b first done", fd, 1'b1);
    chk("R2 b2b first accept", fa, 1'b1);
    chk("R2 b2b no extra done", ad, 1'b0);
    @(negedge clk); sof = 0; vld = 0;
    chk("R2 b2b second done", done_o, 1'b1);
    chk("R8 b2b second drop", accept_o, 1'b0);

    // R10 bytes after a completed address
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      if (j > 0) chk("R10 no start after done", done_o, 1'b0);
      vld = 1; sof = 0; byt = 8'h02;
    end
    @(negedge clk); vld = 0;
    chk("R10 no start after done", done_o, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule